// File: doc/BRIEF.md
# Transceiver Operating Mode Controller

This block decides the operating mode of a bus transceiver from two asynchronous host control pins. It runs on the transceiver's internal oscillator. It synchronises the two pins and filters them against glitches. It then runs a five-mode state machine: active, listen-only, idle (standby), pre-sleep and sleep. The block drives the current mode code and an enable for the external supply regulator switch, which is released only while the transceiver sleeps.

The awake pin is active high. Together with the enable pin it selects the mode. When the awake pin falls while the enable pin is still high, the block does not drop straight into sleep. It passes through a short, timed pre-sleep state, and an enable fall seen during that window turns the request into idle instead. A host that releases both pins lets the internal pull-downs take it to idle. A wake-event level and a supply-undervoltage level are also used:

- The wake-event level brings the block out of sleep.
- The undervoltage level keeps it out of the two active modes.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: After reset the mode code is 2 (idle) and the regulator enable is 1. Both filtered pin levels start at 0.
- R2: A pin level that is sampled on 3 consecutive rising edges becomes the filtered level on the following edge. The mode register follows one edge later, so a pin change driven between edges shows on the mode code after exactly 5 rising edges and not after 4.
- R3: A pin level that is present on only 2 sampling edges never reaches the filtered level and leaves the mode unchanged.
- R4: From an awake mode the filtered pins (awake, enable) decode as follows: (1,1) gives code 0 (active), (1,0) gives code 1 (listen-only) and (0,0) gives code 2 (idle).
- R5: Filtered (awake, enable) = (0,1) moves an awake mode to code 3 (pre-sleep). After SLEEP_WAIT (default 2) cycles in pre-sleep with no change, the mode becomes code 4 (sleep).
- R6: A filtered enable fall seen while in pre-sleep moves the mode to idle. This takes priority over the timeout in the same cycle, so an enable pin edge that lags the awake pin edge by up to SLEEP_WAIT periods ends in idle, and a larger lag ends in sleep.
- R7: In sleep the enable pin is ignored: toggling it leaves the mode at code 4.
- R8: In sleep, a filtered awake level of 1 leaves sleep and decodes as in R4. Without it, a wake-event level of 1 on an edge moves the mode to idle on that edge.
- R9: While the undervoltage input is 1, the next mode is never active or listen-only: those go to idle on the next edge. When undervoltage clears, the mode follows the pins on the next edge.
- R10: The regulator enable is 0 exactly when the mode code is 4 and is 1 in every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| awake_pin_i | input | 1 | Host awake request pin, asynchronous, reads 0 when undriven |
| enable_pin_i | input | 1 | Host enable pin, asynchronous, reads 0 when undriven |
| wake_i | input | 1 | Wake-event level, synchronous |
| uv_i | input | 1 | Supply undervoltage level, synchronous |
| mode_o | output | 3 | Mode code: 0 active, 1 listen-only, 2 idle, 3 pre-sleep, 4 sleep |
| reg_on_o | output | 1 | Regulator switch enable, low only in sleep |

## Verification
Two events can land on the same edge in pre-sleep: the timeout expiring and the filtered enable fall. The bench provokes this by sweeping the lag between the awake and enable pin falls from zero to five oscillator periods. A lag of exactly SLEEP_WAIT periods puts the enable fall on the timeout edge. The final mode is judged against an expected value computed from the lag, which is idle up to and including SLEEP_WAIT and sleep beyond it. The regulator enable and the intermediate pre-sleep code are checked at fixed edge counts along the way.

// File: rtl/xmc_pkg.sv
package xmc_pkg;

    typedef enum logic [2:0] {
        MODE_ACTIVE   = 3'd0,
        MODE_LISTEN   = 3'd1,
        MODE_IDLE     = 3'd2,
        MODE_PRESLEEP = 3'd3,
        MODE_SLEEP    = 3'd4
    } mode_e;

endpackage

// File: rtl/xmc_pin_filter.sv
module xmc_pin_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o
);

    typedef struct packed {
        logic [FILT_LEN-1:0] hist;
        logic                level;
    } filt_s;

    filt_s cur_q, nxt_d;

    // Shift in one sample per edge; the level flips only when the whole
    // history window agrees on the opposite value.
    always_comb begin
        nxt_d      = cur_q;
        nxt_d.hist = {cur_q.hist[FILT_LEN-2:0], pin_i};
        if (&cur_q.hist) begin
            nxt_d.level = 1'b1;
        end else if (~|cur_q.hist) begin
            nxt_d.level = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign level_o = cur_q.level;

endmodule

// File: rtl/xmc_mode_fsm.sv
module xmc_mode_fsm
    import xmc_pkg::*;
#(
    parameter int SLEEP_WAIT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       awake_f_i,
    input  logic       enable_f_i,
    input  logic       wake_i,
    input  logic       uv_i,
    output logic [2:0] mode_o,
    output logic       reg_on_o
);

    localparam int TW = $clog2(SLEEP_WAIT + 1);
    localparam logic [TW-1:0] TMR_LAST = TW'(SLEEP_WAIT - 1);

    typedef struct packed {
        mode_e         mode;
        logic [TW-1:0] tmr;
        logic          reg_on;
    } st_s;

    st_s st_q, st_d;

    function automatic mode_e awake_target(input logic en, input logic uv);
        if (uv) begin
            return MODE_IDLE;
        end
        return en ? MODE_ACTIVE : MODE_LISTEN;
    endfunction

    always_comb begin
        st_d     = st_q;
        st_d.tmr = '0;
        unique case (st_q.mode)
            MODE_ACTIVE, MODE_LISTEN, MODE_IDLE: begin
                if (awake_f_i) begin
                    st_d.mode = awake_target(enable_f_i, uv_i);
                end else if (enable_f_i) begin
                    st_d.mode = MODE_PRESLEEP;
                end else begin
                    st_d.mode = MODE_IDLE;
                end
            end
            MODE_PRESLEEP: begin
                if (awake_f_i) begin
                    st_d.mode = awake_target(enable_f_i, uv_i);
                end else if (!enable_f_i) begin
                    st_d.mode = MODE_IDLE;
                end else if (st_q.tmr == TMR_LAST) begin
                    st_d.mode = MODE_SLEEP;
                end else begin
                    st_d.tmr = st_q.tmr + 1'b1;
                end
            end
            MODE_SLEEP: begin
                if (awake_f_i) begin
                    st_d.mode = awake_target(enable_f_i, uv_i);
                end else if (wake_i) begin
                    st_d.mode = MODE_IDLE;
                end
            end
            default: st_d.mode = MODE_IDLE;
        endcase
        st_d.reg_on = (st_d.mode != MODE_SLEEP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode   <= MODE_IDLE;
            st_q.tmr    <= '0;
            st_q.reg_on <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o   = st_q.mode;
    assign reg_on_o = st_q.reg_on;

endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl #(
    parameter int FILT_LEN   = 3,
    parameter int SLEEP_WAIT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       awake_pin_i,
    input  logic       enable_pin_i,
    input  logic       wake_i,
    input  logic       uv_i,
    output logic [2:0] mode_o,
    output logic       reg_on_o
);

    localparam int NPINS = 2;

    logic [NPINS-1:0] raw_w;
    logic [NPINS-1:0] filt_w;

    assign raw_w = {enable_pin_i, awake_pin_i};

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        xmc_pin_filter #(
            .FILT_LEN(FILT_LEN)
        ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (raw_w[i]),
            .level_o(filt_w[i])
        );
    end

    xmc_mode_fsm #(
        .SLEEP_WAIT(SLEEP_WAIT)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .awake_f_i (filt_w[0]),
        .enable_f_i(filt_w[1]),
        .wake_i    (wake_i),
        .uv_i      (uv_i),
        .mode_o    (mode_o),
        .reg_on_o  (reg_on_o)
    );

endmodule

// File: rtl/xmc_mode_chk.sv
module xmc_mode_chk
    import xmc_pkg::*;
#(
    parameter int SLEEP_WAIT = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wake_i,
    input logic       uv_i,
    input logic [2:0] mode_o,
    input logic       reg_on_o
);

    localparam int CW = $clog2(SLEEP_WAIT + 2);
    localparam logic [CW-1:0] CMAX = CW'(SLEEP_WAIT + 1);

    logic [CW-1:0] pre_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt_q <= '0;
        end else if (mode_o == MODE_PRESLEEP) begin
            if (pre_cnt_q != CMAX) begin
                pre_cnt_q <= pre_cnt_q + 1'b1;
            end
        end else begin
            pre_cnt_q <= '0;
        end
    end

    AST_REGON_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        reg_on_o == (mode_o != MODE_SLEEP)); // R10

    AST_SLEEP_VIA_PRESLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_SLEEP && $past(mode_o) != MODE_SLEEP)
        |-> $past(mode_o) == MODE_PRESLEEP); // R5

    AST_PRESLEEP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_PRESLEEP) |-> (pre_cnt_q < CW'(SLEEP_WAIT))); // R5

    AST_UV_BLOCKS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        uv_i |=> (mode_o != MODE_ACTIVE && mode_o != MODE_LISTEN)); // R9

    AST_WAKE_LEAVES_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_SLEEP && wake_i) |=> (mode_o != MODE_SLEEP)); // R8

endmodule

bind xcvr_mode_ctrl xmc_mode_chk #(
    .SLEEP_WAIT(SLEEP_WAIT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wake_i  (wake_i),
    .uv_i    (uv_i),
    .mode_o  (mode_o),
    .reg_on_o(reg_on_o)
);

// File: tb/xcvr_mode_ctrl_test.sv
`timescale 1ns/1ps
module xcvr_mode_ctrl_test;

    localparam int SW = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       awake = 1'b0;
    logic       en = 1'b0;
    logic       wake = 1'b0;
    logic       uv = 1'b0;
    logic [2:0] mode;
    logic       reg_on;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    xcvr_mode_ctrl #(.FILT_LEN(3), .SLEEP_WAIT(SW)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .awake_pin_i (awake),
        .enable_pin_i(en),
        .wake_i      (wake),
        .uv_i        (uv),
        .mode_o      (mode),
        .reg_on_o    (reg_on)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int awake_exp(input int p);
        case (p)
            3:       return 0;
            2:       return 1;
            default: return 2;
        endcase
    endfunction

    initial begin
        int pats[3] = '{3, 2, 0};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset mode", int'(mode), 2);
        chk("R1 reset reg_on", int'(reg_on), 1);

        // R4 / R2: sweep of awake-mode pin pairs with latency check
        foreach (pats[a]) begin
            foreach (pats[b]) begin
                awake = pats[a][1]; en = pats[a][0];
                step(10);
                chk("R4 settle", int'(mode), awake_exp(pats[a]));
                awake = pats[b][1]; en = pats[b][0];
                step(4);
                chk("R2 not yet at 4 edges", int'(mode), awake_exp(pats[a]));
                step(1);
                chk("R4 decode at 5 edges", int'(mode), awake_exp(pats[b]));
            end
        end

        // R3: two-sample glitches are filtered
        awake = 1; en = 1; step(10);
        awake = 0; step(2); awake = 1; step(10);
        chk("R3 awake glitch", int'(mode), 0);
        chk("R3 awake glitch reg_on", int'(reg_on), 1);
        en = 0; step(10);
        en = 1; step(2); en = 0; step(10);
        chk("R3 enable glitch", int'(mode), 1);

        // R2: a three-sample pulse does pass
        en = 1; step(10);
        awake = 0; step(3); awake = 1; step(2);
        chk("R2 three-sample pulse", int'(mode), 3);
        step(10);
        chk("R2 back to active", int'(mode), 0);

        // R5 / R6 / R10: lag sweep between awake fall and enable fall
        for (int d = 0; d <= 5; d++) begin
            awake = 1; en = 1; step(10);
            awake = 0;
            if (d == 0) en = 0;
            for (int t = 1; t <= 12; t++) begin
                @(posedge clk); @(negedge clk);
                if (t == d) en = 0;
                if (t == 5) chk("R5 presleep entry", int'(mode), (d == 0) ? 2 : 3);
            end
            chk("R6 lag outcome", int'(mode), (d <= SW) ? 2 : 4);
            chk("R10 reg_on after lag", int'(reg_on), (d <= SW) ? 1 : 0);
        end

        // R7: enable ignored in sleep
        awake = 1; en = 1; step(10);
        awake = 0; step(12);
        chk("R5 sleep reached", int'(mode), 4);
        chk("R10 reg_on in sleep", int'(reg_on), 0);
        en = 0; step(8);
        chk("R7 enable fall ignored", int'(mode), 4);
        en = 1; step(8);
        chk("R7 enable rise ignored", int'(mode), 4);
        en = 0; step(8);
        chk("R7 still sleep", int'(mode), 4);

        // R8: wake event exit
        wake = 1; step(1); wake = 0;
        chk("R8 wake to idle", int'(mode), 2);
        chk("R10 reg_on after wake", int'(reg_on), 1);
        step(5);
        chk("R8 idle holds", int'(mode), 2);

        // R8: awake pin exit from sleep
        awake = 1; en = 1; step(10);
        awake = 0; step(12);
        chk("R8 sleep again", int'(mode), 4);
        awake = 1; en = 0;
        step(4);
        chk("R8 still sleep at 4 edges", int'(mode), 4);
        step(1);
        chk("R8 awake exit to listen", int'(mode), 1);

        // R9: undervoltage
        awake = 1; en = 1; step(10);
        chk("R9 active before uv", int'(mode), 0);
        uv = 1; step(1);
        chk("R9 uv forces idle", int'(mode), 2);
        en = 0; step(8);
        chk("R9 uv blocks listen", int'(mode), 2);
        uv = 0; step(1);
        chk("R9 recovery follows pins", int'(mode), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all-requirements actual=hung expected=complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule